// File: doc/BRIEF.md
# Gradient orientation folding unit

This unit sits between a gradient-angle stage and two vote memories of a line detector. It accepts a signed edge-gradient angle in whole degrees, together with a displacement value ρ and a valid strobe, and produces two orientations. The full orientation lies in [0, 179] and addresses a one-bit direction map. The folded orientation lies in [0, FOLD-1] and addresses an accumulator that is reduced along the angle axis by the region count. The fold index (the quotient) is passed out with them, so that the two memories can be compared later.

Negative angles are wrapped by adding the half-turn span. An input of exactly plus or minus the span maps to 0. The wrapped angle is then split by floor division with the fold interval, which is the span divided by the region count (45 degrees with the defaults). The division is done by comparing the angle against each multiple of the interval, not by a general divider. ρ and the strobe travel through a delay line whose length matches the two-stage angle path, so all outputs of one sample appear in the same cycle.

Top module: `orient_fold_unit`

## Requirements
- R1: vld_o equals ang_vld_i delayed by exactly 2 clock cycles.
- R2: An input angle a in [-179, -1] yields a full orientation theta_g_o = a + 180.
- R3: An input angle of exactly -180 or +180 yields theta_g_o = 0.
- R4: An input angle a in [0, 179] yields theta_g_o = a unchanged, and theta_g_o never exceeds 179.
- R5: quot_o = floor(theta_g_o / 45), giving 0 for [0,44], 1 for [45,89], 2 for [90,134] and 3 for [135,179].
- R6: theta_a_o = theta_g_o - 45*quot_o, always in [0, 44].
- R7: rho_o equals rho_i from the same sample, unchanged and delayed by 2 cycles in step with the angle outputs.
- R8: While rst_ni is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ang_vld_i | input | 1 | Input sample valid |
| ang_i | input | 9 | Signed gradient angle in degrees, range [-180, 180] |
| rho_i | input | 12 | Displacement value carried alongside the angle |
| vld_o | output | 1 | Output sample valid |
| theta_g_o | output | 8 | Full orientation, 0 to 179 |
| theta_a_o | output | 6 | Folded orientation, 0 to 44 |
| quot_o | output | 2 | Fold index, 0 to 3 |
| rho_o | output | 12 | Delayed displacement value |

## Verification
The bench builds the unit with its defaults: a 180-degree span, four regions (so a 45-degree interval), a 9-bit signed angle and a 12-bit ρ. With these values every quotient from 0 to 3 is reachable, and each fold threshold can be hit on both sides (44/45, 89/90, 134/135), from positive inputs and from wrapped negative inputs. The two span endpoints and -1, the largest wrapped value, are also within reach. The directed corners are mixed with random angles across the whole signed range and with random gaps in the strobe.

// File: rtl/orient_fold_pkg.sv
package orient_fold_pkg;
  localparam int unsigned SPAN_DEG_DEF = 180;
  localparam int unsigned N_RGN_DEF    = 4;
  localparam int unsigned ANG_W_DEF    = 9;
  localparam int unsigned RHO_W_DEF    = 12;
  localparam int unsigned PIPE_LAT     = 2;
endpackage

// File: rtl/orient_wrap.sv
module orient_wrap #(
  parameter int unsigned ANG_W    = 9,
  parameter int unsigned SPAN_DEG = 180,
  parameter int unsigned TG_W     = $clog2(SPAN_DEG)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic signed [ANG_W-1:0] ang_i,
  output logic        [TG_W-1:0]  theta_g_o
);
  localparam logic signed [ANG_W:0] SPAN_S = (ANG_W+1)'(SPAN_DEG);

  logic signed [ANG_W:0] a_x, w_x;
  logic [TG_W-1:0]       g_d;

  always_comb begin
    a_x = {ang_i[ANG_W-1], ang_i};
    w_x = a_x[ANG_W] ? a_x + SPAN_S : a_x;
    // +span (direct or wrapped from -span... only +span reaches here) folds to 0
    if (w_x >= SPAN_S) g_d = '0;
    else               g_d = w_x[TG_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) theta_g_o <= '0;
    else         theta_g_o <= g_d;
  end
endmodule

// File: rtl/orient_split.sv
module orient_split #(
  parameter int unsigned SPAN_DEG = 180,
  parameter int unsigned N_RGN    = 4,
  parameter int unsigned TG_W     = $clog2(SPAN_DEG),
  parameter int unsigned FOLD     = SPAN_DEG / N_RGN,
  parameter int unsigned TA_W     = (FOLD > 1) ? $clog2(FOLD) : 1,
  parameter int unsigned QW       = (N_RGN > 1) ? $clog2(N_RGN) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [TG_W-1:0] theta_g_i,
  output logic [TG_W-1:0] theta_g_o,
  output logic [TA_W-1:0] theta_a_o,
  output logic [QW-1:0]   quot_o
);
  logic [QW-1:0]   q_d;
  logic [TG_W-1:0] base_d;
  logic [TG_W-1:0] rem_d;

  // ascending constant thresholds: the last one passed sets the quotient
  always_comb begin
    q_d    = '0;
    base_d = '0;
    for (int k = 1; k < int'(N_RGN); k++) begin
      if (theta_g_i >= TG_W'(k * FOLD)) begin
        q_d    = QW'(k);
        base_d = TG_W'(k * FOLD);
      end
    end
    rem_d = theta_g_i - base_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      theta_g_o <= '0;
      theta_a_o <= '0;
      quot_o    <= '0;
    end else begin
      theta_g_o <= theta_g_i;
      theta_a_o <= rem_d[TA_W-1:0];
      quot_o    <= q_d;
    end
  end
endmodule

// File: rtl/orient_delay.sv
module orient_delay #(
  parameter int unsigned DW    = 13,
  parameter int unsigned DEPTH = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] d_i,
  output logic [DW-1:0] d_o
);
  logic [DW-1:0] sr [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(DEPTH); i++) sr[i] <= '0;
    end else begin
      sr[0] <= d_i;
      for (int i = 1; i < int'(DEPTH); i++) sr[i] <= sr[i-1];
    end
  end

  assign d_o = sr[DEPTH-1];
endmodule

// File: rtl/orient_fold_unit.sv
module orient_fold_unit
  import orient_fold_pkg::*;
#(
  parameter int unsigned SPAN_DEG = SPAN_DEG_DEF,
  parameter int unsigned N_RGN    = N_RGN_DEF,
  parameter int unsigned ANG_W    = ANG_W_DEF,
  parameter int unsigned RHO_W    = RHO_W_DEF,
  localparam int unsigned TG_W    = $clog2(SPAN_DEG),
  localparam int unsigned FOLD    = SPAN_DEG / N_RGN,
  localparam int unsigned TA_W    = (FOLD > 1) ? $clog2(FOLD) : 1,
  localparam int unsigned QW      = (N_RGN > 1) ? $clog2(N_RGN) : 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    ang_vld_i,
  input  logic signed [ANG_W-1:0] ang_i,
  input  logic        [RHO_W-1:0] rho_i,
  output logic                    vld_o,
  output logic        [TG_W-1:0]  theta_g_o,
  output logic        [TA_W-1:0]  theta_a_o,
  output logic        [QW-1:0]    quot_o,
  output logic        [RHO_W-1:0] rho_o
);
  logic [TG_W-1:0] g_s1;

  orient_wrap #(.ANG_W(ANG_W), .SPAN_DEG(SPAN_DEG), .TG_W(TG_W)) u_wrap (
    .clk_i, .rst_ni, .ang_i, .theta_g_o(g_s1)
  );

  orient_split #(
    .SPAN_DEG(SPAN_DEG), .N_RGN(N_RGN), .TG_W(TG_W),
    .FOLD(FOLD), .TA_W(TA_W), .QW(QW)
  ) u_split (
    .clk_i, .rst_ni, .theta_g_i(g_s1),
    .theta_g_o, .theta_a_o, .quot_o
  );

  orient_delay #(.DW(RHO_W + 1), .DEPTH(PIPE_LAT)) u_side (
    .clk_i, .rst_ni,
    .d_i({ang_vld_i, rho_i}),
    .d_o({vld_o, rho_o})
  );
endmodule

// File: rtl/orient_fold_chk.sv
module orient_fold_chk #(
  parameter int unsigned SPAN_DEG = 180,
  parameter int unsigned N_RGN    = 4,
  parameter int unsigned ANG_W    = 9,
  parameter int unsigned RHO_W    = 12,
  parameter int unsigned TG_W     = 8,
  parameter int unsigned TA_W     = 6,
  parameter int unsigned QW       = 2
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    ang_vld_i,
  input logic signed [ANG_W-1:0] ang_i,
  input logic        [RHO_W-1:0] rho_i,
  input logic                    vld_o,
  input logic        [TG_W-1:0]  theta_g_o,
  input logic        [TA_W-1:0]  theta_a_o,
  input logic        [QW-1:0]    quot_o,
  input logic        [RHO_W-1:0] rho_o
);
  localparam int FOLD = int'(SPAN_DEG / N_RGN);
  logic [1:0] seen;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          seen <= '0;
    else if (seen != 2'd2) seen <= seen + 2'd1;
  end

  // R1
  vld_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen == 2'd2) |-> (vld_o == $past(ang_vld_i, 2)));

  // R7
  rho_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen == 2'd2) |-> (rho_o == $past(rho_i, 2)));

  // R4
  g_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(theta_g_o) < int'(SPAN_DEG));

  // R6
  a_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(theta_a_o) < FOLD);

  // R5
  recombine_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(theta_g_o) == int'(quot_o) * FOLD + int'(theta_a_o));

  // R2
  neg_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen == 2'd2 && $past(ang_i, 2) < 0 && $past(ang_i, 2) > -int'(SPAN_DEG))
      |-> (int'(theta_g_o) == int'($past(ang_i, 2)) + int'(SPAN_DEG)));
endmodule

bind orient_fold_unit orient_fold_chk #(
  .SPAN_DEG(SPAN_DEG), .N_RGN(N_RGN), .ANG_W(ANG_W), .RHO_W(RHO_W),
  .TG_W(TG_W), .TA_W(TA_W), .QW(QW)
) u_chk (
  .clk_i, .rst_ni, .ang_vld_i, .ang_i, .rho_i,
  .vld_o, .theta_g_o, .theta_a_o, .quot_o, .rho_o
);

// File: tb/sim_orient_fold_unit.sv
`timescale 1ns/1ps
module sim_orient_fold_unit;
  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              ang_vld_i = 1'b0;
  logic signed [8:0] ang_i = '0;
  logic [11:0]       rho_i = '0;
  logic              vld_o;
  logic [7:0]        theta_g_o;
  logic [5:0]        theta_a_o;
  logic [1:0]        quot_o;
  logic [11:0]       rho_o;

  int tests = 0;
  int fails = 0;

  // history of driven samples, index 1 = two cycles ago
  int h_ang [2];
  int h_rho [2];
  bit h_vld [2];

  orient_fold_unit u0 (
    .clk_i, .rst_ni, .ang_vld_i, .ang_i, .rho_i,
    .vld_o, .theta_g_o, .theta_a_o, .quot_o, .rho_o
  );

  always #4 clk_i = ~clk_i;

  function automatic int exp_g(int a);
    int g;
    g = (a < 0) ? a + 180 : a;
    if (g == 180) g = 0;
    return g;
  endfunction

  task automatic chk(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // called at negedge: check outputs of sample from two edges ago, then drive
  task automatic step(bit v, int a, int r);
    int g;
    chk("R1 valid", int'(vld_o), int'(h_vld[1]));
    if (h_vld[1]) begin
      g = exp_g(h_ang[1]);
      if (h_ang[1] == 180 || h_ang[1] == -180) chk("R3 endpoint", int'(theta_g_o), g);
      else if (h_ang[1] < 0)                   chk("R2 wrap", int'(theta_g_o), g);
      else                                     chk("R4 pass", int'(theta_g_o), g);
      chk("R5 quot", int'(quot_o), g / 45);
      chk("R6 fold", int'(theta_a_o), g % 45);
      chk("R7 rho", int'(rho_o), h_rho[1]);
    end
    h_vld[1] = h_vld[0]; h_ang[1] = h_ang[0]; h_rho[1] = h_rho[0];
    h_vld[0] = v;        h_ang[0] = a;        h_rho[0] = r;
    ang_vld_i = v;
    ang_i     = 9'(a);
    rho_i     = 12'(r);
    @(negedge clk_i);
  endtask

  initial begin
    #(8 * 50000);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int seed;
    int corners [17] = '{-180, 180, -1, 0, 1, 44, 45, 89, 90, 134, 135, 179,
                         -135, -136, -45, -46, -91};
    seed = 32'h5eed;
    void'($urandom(seed));
    for (int i = 0; i < 2; i++) begin h_vld[i] = 0; h_ang[i] = 0; h_rho[i] = 0; end
    ang_vld_i = 1'b1; ang_i = 9'sd100; rho_i = 12'hfff;
    repeat (3) @(negedge clk_i);
    // R8 reset state with active inputs
    chk("R8 reset vld", int'(vld_o), 0);
    chk("R8 reset g", int'(theta_g_o), 0);
    chk("R8 reset a", int'(theta_a_o), 0);
    chk("R8 reset q", int'(quot_o), 0);
    chk("R8 reset rho", int'(rho_o), 0);
    ang_vld_i = 1'b0;
    rst_ni = 1'b1;
    @(negedge clk_i);
    foreach (corners[i]) step(1'b1, corners[i], 100 + i);
    step(1'b0, 77, 5);
    step(1'b1, -180, 4095);
    step(1'b0, 0, 0);
    step(1'b1, 180, 1);
    for (int i = 0; i < 400; i++)
      step(($urandom % 4) != 0, int'($urandom_range(360)) - 180, int'($urandom % 4096));
    step(1'b0, 0, 0);
    step(1'b0, 0, 0);
    step(1'b0, 0, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule